// File: doc/BRIEF.md
# Pipeline Forwarding and Interlock Unit

This block is the data-hazard control for an in-order, five-stage integer pipeline (fetch, decode, execute, memory, writeback, one cycle each). It compares the source register numbers of the instruction in execute against the destination numbers held in the two later pipeline latches. From that it drives the select of each execute-stage operand multiplexer, so that an instruction takes a fresh result from the execute/memory latch or the memory/writeback latch instead of a stale register-file value.

It also compares the decode-stage sources against the destination of the instruction in execute. When that instruction is a load, its data is not available in time. The unit then freezes the program counter and the fetch/decode latch for one cycle and places a no-op bubble into execute. The register file writes in the first half of a cycle and reads in the second half, so a consumer three places behind its producer reads the new value directly and needs no path from writeback to decode.

Top module: `hazard_unit`

## Requirements
- R1: When the execute/memory latch writes (mem_we_i=1) a nonzero register equal to an execute-stage source, that operand's select is 2'b10 (take the execute/memory result).
- R2: When only the memory/writeback latch writes (wb_we_i=1) a nonzero register equal to an execute-stage source, that operand's select is 2'b01 (take the memory/writeback result).
- R3: When both latches match the same source, the select is 2'b10: the younger producer wins.
- R4: Register 0, and any producer whose write enable is low, never matches; with no match the select is 2'b00 (register-file value).
- R5: A producer in writeback that matches a decode-stage source causes no stall.
- R6: A load in execute (ex_load_i=1, ex_we_i=1, nonzero ex_dst_i) whose destination equals a used decode-stage source raises stall_o=1, front_we_o=0 and bubble_o=1 in the same cycle; a load writing register 0 stalls nothing.
- R7: A non-load producer in execute never stalls, so a chain of dependent ALU instructions runs with no bubble and forwards 2'b10 then 2'b01 to its consumers.
- R8: Each of the two operands (operand i uses bits [i*5 +: 5] of the source buses and bits [i*2 +: 2] of fwd_sel_o) is forwarded and interlocked on its own sources only.
- R9: A decode-stage source whose use flag is 0 never causes a stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock (used by the built-in checks) |
| rst_ni | input | 1 | Active-low asynchronous reset |
| id_src_i | input | 10 | Two decode-stage source register numbers |
| id_src_use_i | input | 2 | Decode-stage source actually read |
| ex_src_i | input | 10 | Two execute-stage source register numbers |
| ex_dst_i | input | 5 | Destination of the instruction in execute |
| ex_we_i | input | 1 | Instruction in execute writes a register |
| ex_load_i | input | 1 | Instruction in execute is a load |
| mem_dst_i | input | 5 | Destination held in the execute/memory latch |
| mem_we_i | input | 1 | Execute/memory latch writes a register |
| wb_dst_i | input | 5 | Destination held in the memory/writeback latch |
| wb_we_i | input | 1 | Memory/writeback latch writes a register |
| fwd_sel_o | output | 4 | Operand selects, two bits per operand |
| stall_o | output | 1 | Load-use interlock active |
| front_we_o | output | 1 | Write enable of PC and fetch/decode latch |
| bubble_o | output | 1 | Insert a no-op into execute |

## Verification
Every cycle the assertions check that register 0 never produces a forward, that a matching execute/memory producer always takes precedence, that a stall always comes with frozen front latches and a bubble, and that neither a non-load producer nor an unused source can raise a stall. Only the bench scenarios show the exact select code for each mix of producers, that the two operands do not disturb each other, that a writeback-stage producer needs neither forward nor stall, and that an ALU dependency chain steps through both forward paths without a bubble.

// File: rtl/hazard_pkg.sv
package hazard_pkg;
  typedef enum logic [1:0] {
    SEL_RF  = 2'b00,
    SEL_WB  = 2'b01,
    SEL_MEM = 2'b10
  } fwd_sel_e;
endpackage

// File: rtl/fwd_select.sv
module fwd_select
  import hazard_pkg::*;
#(
  parameter int unsigned AW = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] src_i,
  input  logic [AW-1:0] mem_dst_i,
  input  logic          mem_we_i,
  input  logic [AW-1:0] wb_dst_i,
  input  logic          wb_we_i,
  output fwd_sel_e      sel_o
);
  logic mem_hit, wb_hit;

  assign mem_hit = mem_we_i && (mem_dst_i != '0) && (mem_dst_i == src_i);
  assign wb_hit  = wb_we_i  && (wb_dst_i  != '0) && (wb_dst_i  == src_i);

  always_comb begin
    if (mem_hit)     sel_o = SEL_MEM;  // younger producer first
    else if (wb_hit) sel_o = SEL_WB;
    else             sel_o = SEL_RF;
  end

  AST_NO_FWD_ZERO_REG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_i == '0) |-> (sel_o == SEL_RF)); // R4

  AST_MEM_PRIORITY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_i && src_i != '0 && mem_dst_i == src_i) |-> (sel_o == SEL_MEM)); // R3

  AST_NO_FWD_NO_WE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mem_we_i && !wb_we_i) |-> (sel_o == SEL_RF)); // R4
endmodule

// File: rtl/load_use_detect.sv
module load_use_detect #(
  parameter int unsigned AW = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] src_i,
  input  logic          use_i,
  input  logic [AW-1:0] ex_dst_i,
  input  logic          ex_we_i,
  input  logic          ex_load_i,
  output logic          hit_o
);
  logic dst_valid;

  assign dst_valid = ex_load_i && ex_we_i && (ex_dst_i != '0);
  assign hit_o     = dst_valid && use_i && (ex_dst_i == src_i);

  AST_UNUSED_NO_HIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !use_i |-> !hit_o); // R9

  AST_ZERO_DST_NO_HIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ex_dst_i == '0) |-> !hit_o); // R6
endmodule

// File: rtl/hazard_unit.sv
module hazard_unit
  import hazard_pkg::*;
#(
  parameter int unsigned AW      = 5,
  parameter int unsigned NUM_SRC = 2
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [NUM_SRC*AW-1:0] id_src_i,
  input  logic [NUM_SRC-1:0]    id_src_use_i,
  input  logic [NUM_SRC*AW-1:0] ex_src_i,
  input  logic [AW-1:0]         ex_dst_i,
  input  logic                  ex_we_i,
  input  logic                  ex_load_i,
  input  logic [AW-1:0]         mem_dst_i,
  input  logic                  mem_we_i,
  input  logic [AW-1:0]         wb_dst_i,
  input  logic                  wb_we_i,
  output logic [NUM_SRC*2-1:0]  fwd_sel_o,
  output logic                  stall_o,
  output logic                  front_we_o,
  output logic                  bubble_o
);
  localparam int unsigned SW = 2;

  logic [NUM_SRC-1:0] lu_hit;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    fwd_sel_e sel;

    fwd_select #(.AW(AW)) u_fwd (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .src_i    (ex_src_i[i*AW +: AW]),
      .mem_dst_i(mem_dst_i),
      .mem_we_i (mem_we_i),
      .wb_dst_i (wb_dst_i),
      .wb_we_i  (wb_we_i),
      .sel_o    (sel)
    );
    assign fwd_sel_o[i*SW +: SW] = sel;

    load_use_detect #(.AW(AW)) u_lu (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .src_i    (id_src_i[i*AW +: AW]),
      .use_i    (id_src_use_i[i]),
      .ex_dst_i (ex_dst_i),
      .ex_we_i  (ex_we_i),
      .ex_load_i(ex_load_i),
      .hit_o    (lu_hit[i])
    );
  end

  assign stall_o    = |lu_hit;
  assign front_we_o = ~stall_o;
  assign bubble_o   = stall_o;

  AST_STALL_FREEZES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |-> (!front_we_o && bubble_o)); // R6

  AST_ALU_NO_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ex_load_i |-> (!stall_o && front_we_o && !bubble_o)); // R7

  AST_IDLE_NO_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (id_src_use_i == '0) |-> !stall_o); // R9
endmodule

// File: tb/hazard_unit_tb.sv
module hazard_unit_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [9:0]  id_src_i, ex_src_i;
  logic [1:0]  id_src_use_i;
  logic [4:0]  ex_dst_i, mem_dst_i, wb_dst_i;
  logic        ex_we_i, ex_load_i, mem_we_i, wb_we_i;
  logic [3:0]  fwd_sel_o;
  logic        stall_o, front_we_o, bubble_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #10 clk_i = ~clk_i;  // 50 MHz

  hazard_unit dut_i (
    .clk_i, .rst_ni, .id_src_i, .id_src_use_i, .ex_src_i,
    .ex_dst_i, .ex_we_i, .ex_load_i, .mem_dst_i, .mem_we_i,
    .wb_dst_i, .wb_we_i, .fwd_sel_o, .stall_o, .front_we_o, .bubble_o
  );

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic idle();
    id_src_i = '0; id_src_use_i = '0; ex_src_i = '0;
    ex_dst_i = '0; ex_we_i = 0; ex_load_i = 0;
    mem_dst_i = '0; mem_we_i = 0; wb_dst_i = '0; wb_we_i = 0;
  endtask

  task automatic settle();
    #4;
  endtask

  task automatic stall_chk(input string req, input logic exp);
    chk(req, {1'b0, stall_o, front_we_o, bubble_o}, {1'b0, exp, ~exp, exp});
  endtask

  task automatic t_reset();
    @(negedge clk_i); idle(); settle();
    chk("R4 reset select", fwd_sel_o, 4'b0000);
    stall_chk("R7 reset stall", 1'b0);
  endtask

  task automatic t_fwd_mem();
    @(negedge clk_i); idle();
    ex_src_i = {5'd2, 5'd3}; mem_dst_i = 5'd3; mem_we_i = 1; settle();
    chk("R1 mem forward op0", fwd_sel_o, 4'b0010);
  endtask

  task automatic t_fwd_wb();
    @(negedge clk_i); idle();
    ex_src_i = {5'd7, 5'd1}; wb_dst_i = 5'd7; wb_we_i = 1; settle();
    chk("R2 wb forward op1", fwd_sel_o, 4'b0100);
  endtask

  task automatic t_prio();
    @(negedge clk_i); idle();
    ex_src_i = {5'd9, 5'd9}; mem_dst_i = 5'd9; mem_we_i = 1;
    wb_dst_i = 5'd9; wb_we_i = 1; settle();
    chk("R3 younger wins", fwd_sel_o, 4'b1010);
  endtask

  task automatic t_zero();
    @(negedge clk_i); idle();
    ex_src_i = {5'd0, 5'd0}; mem_dst_i = 5'd0; mem_we_i = 1;
    wb_dst_i = 5'd0; wb_we_i = 1; settle();
    chk("R4 reg0 no forward", fwd_sel_o, 4'b0000);
    @(negedge clk_i); idle();
    ex_src_i = {5'd4, 5'd4}; mem_dst_i = 5'd4; wb_dst_i = 5'd4; settle();
    chk("R4 we low no forward", fwd_sel_o, 4'b0000);
  endtask

  task automatic t_wb_decode();
    @(negedge clk_i); idle();
    id_src_i = {5'd0, 5'd6}; id_src_use_i = 2'b01;
    wb_dst_i = 5'd6; wb_we_i = 1; settle();
    stall_chk("R5 wb producer no stall", 1'b0);
  endtask

  task automatic t_load_use();
    @(negedge clk_i); idle();
    id_src_i = {5'd11, 5'd0}; id_src_use_i = 2'b10;
    ex_dst_i = 5'd11; ex_we_i = 1; ex_load_i = 1; settle();
    stall_chk("R6 load-use stall", 1'b1);
    @(negedge clk_i); idle();
    id_src_i = {5'd0, 5'd0}; id_src_use_i = 2'b11;
    ex_dst_i = 5'd0; ex_we_i = 1; ex_load_i = 1; settle();
    stall_chk("R6 load to reg0 no stall", 1'b0);
    // following cycle: load moved to MEM/WB via bubble, consumer forwarded from WB
    @(negedge clk_i); idle();
    ex_src_i = {5'd11, 5'd0}; wb_dst_i = 5'd11; wb_we_i = 1; settle();
    chk("R6 post-stall wb forward", fwd_sel_o, 4'b0100);
  endtask

  task automatic t_alu_chain();
    // r5 <- ; r8 <- r5 ; r10 <- r5
    @(negedge clk_i); idle();
    id_src_i = {5'd0, 5'd5}; id_src_use_i = 2'b01;
    ex_dst_i = 5'd5; ex_we_i = 1; settle();
    stall_chk("R7 alu producer no stall", 1'b0);
    @(negedge clk_i); idle();
    ex_src_i = {5'd0, 5'd5}; mem_dst_i = 5'd5; mem_we_i = 1;
    id_src_i = {5'd5, 5'd0}; id_src_use_i = 2'b10;
    ex_dst_i = 5'd8; ex_we_i = 1; settle();
    chk("R7 chain step1 sel", fwd_sel_o, 4'b0010);
    stall_chk("R7 chain step1 stall", 1'b0);
    @(negedge clk_i); idle();
    ex_src_i = {5'd5, 5'd0}; mem_dst_i = 5'd8; mem_we_i = 1;
    wb_dst_i = 5'd5; wb_we_i = 1; settle();
    chk("R7 chain step2 sel", fwd_sel_o, 4'b0100);
  endtask

  task automatic t_independent();
    @(negedge clk_i); idle();
    ex_src_i = {5'd13, 5'd12}; mem_dst_i = 5'd12; mem_we_i = 1;
    wb_dst_i = 5'd13; wb_we_i = 1; settle();
    chk("R8 mixed selects", fwd_sel_o, 4'b0110);
    @(negedge clk_i); idle();
    id_src_i = {5'd14, 5'd15}; id_src_use_i = 2'b11;
    ex_dst_i = 5'd15; ex_we_i = 1; ex_load_i = 1; settle();
    stall_chk("R8 op0 alone stalls", 1'b1);
  endtask

  task automatic t_unused();
    @(negedge clk_i); idle();
    id_src_i = {5'd17, 5'd17}; id_src_use_i = 2'b00;
    ex_dst_i = 5'd17; ex_we_i = 1; ex_load_i = 1; settle();
    stall_chk("R9 unused source", 1'b0);
  endtask

  initial begin
    idle();
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_fwd_mem();
    t_fwd_wb();
    t_prio();
    t_zero();
    t_wb_decode();
    t_load_use();
    t_alu_chain();
    t_independent();
    t_unused();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk_i);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule